// File: doc/BRIEF.md
# I2C Register-Read Slave

This block is the serial front end of a peripheral whose register file mixes 8-bit and 16-bit registers. It follows the two-wire bus: a synchronous sampler, edge and condition detection, a 7-bit address compare, byte shifting on SCL, an ACK driver and open-drain SDA control.

A write transaction selects a register. Its first data byte becomes the register pointer. Any further bytes in the same write are handed to the register file, one pulse per byte. A read transaction returns the selected register over and over for as long as the master acknowledges. A narrow register repeats its single byte. A wide register repeats its high byte followed by its low byte. The pointer never advances, and it keeps its value from one transaction to the next, so a master can poll a register without rewriting the pointer each time.

The register file sits behind a plain port. The block presents `reg_addr`, takes back the data and a width flag, and receives a write strobe with its byte.

Top module: `i2c_regread_slave`

## Requirements
- R1: While reset is held, `sda_oe` is 0, `reg_addr` is 0 and `reg_we` is 0.
- R2: The first byte after START carries the 7-bit slave address in bits 7:1 and the R/W flag in bit 0, where 1 means read. If the address equals `SLV_ADDR`, the block pulls SDA low (`sda_oe`=1) for the ninth clock. If it does not, `sda_oe` stays 0 until the next START or STOP, and neither the pointer nor `reg_we` changes.
- R3: In a write transaction, the first byte after the address byte is acknowledged and loaded into `reg_addr`.
- R4: Every later byte of the same write is acknowledged and gives a single-cycle `reg_we` pulse with the byte on `reg_wdata`. The pointer keeps its value.
- R5: Reads never change `reg_addr`. For a narrow register (`reg_wide`=0), every byte read is `reg_rdata[7:0]`, and bits 15:8 are ignored.
- R6: For a wide register (`reg_wide`=1), the bytes read alternate: bits 15:8 first, then bits 7:0. This pair repeats while the master ACKs.
- R7: A wide value is captured when its high byte is loaded. The low byte of the same pair comes from that capture, even if the register changes between the two bytes.
- R8: After a master NACK on a read byte, `sda_oe` stays 0 until the next START or STOP.
- R9: The pointer keeps its value across STOP, so a later read with no pointer write returns the same register.
- R10: A repeated START that follows the pointer write directly starts a read from the new pointer.
- R11: `sda_oe` changes only while the synchronized SCL is low. It is stable during every SCL high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| reg_addr | output | PTR_W | Register pointer to the register file |
| reg_rdata | input | DATA_W | Contents of the pointed register |
| reg_wide | input | 1 | 1 when the pointed register is 16 bits wide |
| reg_we | output | 1 | Single-cycle write strobe |
| reg_wdata | output | 8 | Byte to write at `reg_addr` |

## Verification
Each SCL or SDA change passes two synchronizer flops and one edge register. The block therefore reacts on the third clock edge after the line moves, and `sda_oe` settles three clocks into the SCL low phase. The bench holds SCL low for eight clocks and changes the master's SDA after the fourth. On every clock of each SCL high phase, it compares `sda_oe` with the value its bus model predicts for that bit, and it also checks that `sda_oe` has not moved since the previous clock. The pointer and the captured write strobes are checked only after the transaction's STOP, when every update is long settled.

// File: rtl/i2c_rr_pkg.sv
package i2c_rr_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_CHK,
        ST_ADDR_ACK,
        ST_WR_BYTE,
        ST_WR_CHK,
        ST_WR_ACK,
        ST_RD_BYTE,
        ST_RD_ACK,
        ST_RD_GO,
        ST_IGNORE
    } rr_state_e;

endpackage

// File: rtl/i2c_rr_sync.sv
module i2c_rr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_seen,
    output logic stop_seen
);
    localparam int PW = STAGES + 1;

    logic [PW-1:0] scl_pipe_q;
    logic [PW-1:0] sda_pipe_q;
    logic          scl_p;
    logic          sda_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe_q <= '1;
            sda_pipe_q <= '1;
        end else begin
            scl_pipe_q <= {scl_pipe_q[PW-2:0], scl_i};
            sda_pipe_q <= {sda_pipe_q[PW-2:0], sda_i};
        end
    end

    // Synchronized level and its one-clock-older copy
    assign scl_s = scl_pipe_q[STAGES-1];
    assign sda_s = sda_pipe_q[STAGES-1];
    assign scl_p = scl_pipe_q[STAGES];
    assign sda_p = sda_pipe_q[STAGES];

    assign scl_rise   = scl_s & ~scl_p;
    assign scl_fall   = ~scl_s & scl_p;
    assign start_seen = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_seen  = scl_s & scl_p & ~sda_p & sda_s;

endmodule

// File: rtl/i2c_rr_txsel.sv
module i2c_rr_txsel #(
    parameter int DATA_W = 16
) (
    input  logic              need_latch,
    input  logic [DATA_W-1:0] pair_q,
    input  logic [DATA_W-1:0] rdata,
    input  logic              wide,
    output logic [7:0]        tx_byte,
    output logic [DATA_W-1:0] pair_next,
    output logic              need_next
);
    localparam int HI_LSB = DATA_W - 8;

    always_comb begin
        if (need_latch) begin
            // Fresh sample: wide sends the high byte now, keeps the rest
            tx_byte   = wide ? rdata[HI_LSB +: 8] : rdata[7:0];
            pair_next = rdata;
            need_next = ~wide;
        end else begin
            tx_byte   = pair_q[7:0];
            pair_next = pair_q;
            need_next = 1'b1;
        end
    end

endmodule

// File: rtl/i2c_regread_slave.sv
module i2c_regread_slave
    import i2c_rr_pkg::*;
#(
    parameter logic [6:0] SLV_ADDR    = 7'h2C,
    parameter int         PTR_W       = 8,
    parameter int         DATA_W      = 16,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    output logic [PTR_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0] reg_rdata,
    input  logic              reg_wide,
    output logic              reg_we,
    output logic [7:0]        reg_wdata
);
    localparam int BIT_W = 3;
    localparam logic [BIT_W-1:0] LAST_BIT = 3'd7;

    typedef struct packed {
        rr_state_e         st;
        logic [BIT_W-1:0]  cnt;
        logic [7:0]        sr;
        logic              rd;
        logic              first_wr;
        logic [PTR_W-1:0]  ptr;
        logic [DATA_W-1:0] pair;
        logic              need;
        logic              mack;
        logic              oe;
        logic              we;
        logic [7:0]        wdata;
    } core_t;

    core_t q, d;

    logic scl_s, sda_s, scl_rise, scl_fall, start_seen, stop_seen;
    logic [7:0]        tx_byte;
    logic [DATA_W-1:0] pair_next;
    logic              need_next;
    rr_state_e         state_w;

    i2c_rr_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_s      (scl_s),
        .sda_s      (sda_s),
        .scl_rise   (scl_rise),
        .scl_fall   (scl_fall),
        .start_seen (start_seen),
        .stop_seen  (stop_seen)
    );

    i2c_rr_txsel #(.DATA_W(DATA_W)) u_txsel (
        .need_latch (q.need),
        .pair_q     (q.pair),
        .rdata      (reg_rdata),
        .wide       (reg_wide),
        .tx_byte    (tx_byte),
        .pair_next  (pair_next),
        .need_next  (need_next)
    );

    always_comb begin
        d    = q;
        d.we = 1'b0;
        if (start_seen) begin
            d.st  = ST_ADDR;
            d.cnt = '0;
            d.oe  = 1'b0;
        end else if (stop_seen) begin
            d.st = ST_IDLE;
            d.oe = 1'b0;
        end else begin
            unique case (q.st)
                ST_ADDR, ST_WR_BYTE: begin
                    if (scl_rise) begin
                        d.sr  = {q.sr[6:0], sda_s};
                        d.cnt = q.cnt + 3'd1;
                        if (q.cnt == LAST_BIT)
                            d.st = (q.st == ST_ADDR) ? ST_ADDR_CHK : ST_WR_CHK;
                    end
                end
                ST_ADDR_CHK: begin
                    if (scl_fall) begin
                        if (q.sr[7:1] == SLV_ADDR) begin
                            d.oe       = 1'b1;
                            d.rd       = q.sr[0];
                            d.first_wr = 1'b1;
                            d.need     = 1'b1;
                            d.st       = ST_ADDR_ACK;
                        end else begin
                            d.st = ST_IGNORE;
                        end
                    end
                end
                ST_ADDR_ACK, ST_RD_GO: begin
                    if (scl_fall) begin
                        d.cnt = '0;
                        if ((q.st == ST_ADDR_ACK && q.rd) || (q.st == ST_RD_GO && q.mack)) begin
                            d.sr   = tx_byte;
                            d.pair = pair_next;
                            d.need = need_next;
                            d.oe   = ~tx_byte[7];
                            d.st   = ST_RD_BYTE;
                        end else if (q.st == ST_ADDR_ACK) begin
                            d.oe = 1'b0;
                            d.st = ST_WR_BYTE;
                        end else begin
                            d.oe = 1'b0;
                            d.st = ST_IGNORE;
                        end
                    end
                end
                ST_WR_CHK: begin
                    if (scl_fall) begin
                        d.oe = 1'b1;
                        d.st = ST_WR_ACK;
                        if (q.first_wr) begin
                            d.ptr      = q.sr[PTR_W-1:0];
                            d.first_wr = 1'b0;
                        end else begin
                            d.we    = 1'b1;
                            d.wdata = q.sr;
                        end
                    end
                end
                ST_WR_ACK: begin
                    if (scl_fall) begin
                        d.oe  = 1'b0;
                        d.cnt = '0;
                        d.st  = ST_WR_BYTE;
                    end
                end
                ST_RD_BYTE: begin
                    if (scl_fall) begin
                        d.cnt = q.cnt + 3'd1;
                        if (q.cnt == LAST_BIT) begin
                            d.oe = 1'b0;
                            d.st = ST_RD_ACK;
                        end else begin
                            d.sr = {q.sr[6:0], 1'b0};
                            d.oe = ~q.sr[6];
                        end
                    end
                end
                ST_RD_ACK: begin
                    if (scl_rise) begin
                        d.mack = ~sda_s;
                        d.st   = ST_RD_GO;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sda_oe    = q.oe;
    assign reg_addr  = q.ptr;
    assign reg_we    = q.we;
    assign reg_wdata = q.wdata;
    assign state_w   = q.st;

endmodule

// File: rtl/i2c_rr_checker.sv
module i2c_rr_checker
    import i2c_rr_pkg::*;
#(
    parameter int PTR_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             scl_s,
    input logic             sda_oe,
    input logic             reg_we,
    input logic [PTR_W-1:0] reg_addr,
    input rr_state_e        st
);

    assert_oe_moves_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_s);

    assert_we_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we);

    assert_ptr_only_on_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(reg_addr) |-> $past(st == ST_WR_CHK));

    assert_release_after_nack_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IGNORE || st == ST_IDLE) |-> !sda_oe);

    assert_drive_only_in_slots_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sda_oe |-> (st inside {ST_ADDR_ACK, ST_WR_ACK, ST_RD_BYTE}));

endmodule

bind i2c_regread_slave i2c_rr_checker #(.PTR_W(PTR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_s    (scl_s),
    .sda_oe   (sda_oe),
    .reg_we   (reg_we),
    .reg_addr (reg_addr),
    .st       (state_w)
);

// File: tb/test_i2c_regread_slave.sv
module test_i2c_regread_slave;
    localparam logic [6:0] ADDR = 7'h2C;
    localparam int LO = 8;
    localparam int HI = 8;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_bus;
    logic sda_oe;
    logic [7:0]  reg_addr;
    logic [15:0] reg_rdata;
    logic        reg_wide;
    logic        reg_we;
    logic [7:0]  reg_wdata;

    logic [15:0] rf_val  [256];
    logic        rf_wide [256];

    assign reg_rdata = rf_val[reg_addr];
    assign reg_wide  = rf_wide[reg_addr];
    assign sda_bus   = sda_m & ~sda_oe;

    i2c_regread_slave i_i2c_regread_slave (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_m),
        .sda_i     (sda_bus),
        .sda_oe    (sda_oe),
        .reg_addr  (reg_addr),
        .reg_rdata (reg_rdata),
        .reg_wide  (reg_wide),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata)
    );

    int    compared   = 0;
    int    mismatched = 0;
    logic  exp_oe     = 1'b0;
    string tag        = "R2";
    logic  prev_scl   = 1'b1;
    logic  prev_oe    = 1'b0;
    bit    done       = 1'b0;
    logic [7:0] wq[$];
    logic [7:0] wa[$];

    // Per-clock comparison against the bus model's expected SDA drive
    always @(negedge clk) begin
        if (rst_n) begin
            if (scl_m) begin
                compared++;
                if (sda_oe !== exp_oe) begin
                    mismatched++;
                    $display("FAIL %s: sda_oe actual %0b expected %0b at %0t", tag, sda_oe, exp_oe, $time);
                end
                if (prev_scl) begin
                    compared++;
                    if (sda_oe !== prev_oe) begin
                        mismatched++;
                        $display("FAIL R11: sda_oe actual %0b expected %0b (moved during SCL high)", sda_oe, prev_oe);
                    end
                end
            end
            if (reg_we) begin
                wq.push_back(reg_wdata);
                wa.push_back(reg_addr);
            end
        end
        prev_scl = scl_m;
        prev_oe  = sda_oe;
    end

    task automatic chk(input string t, input logic [31:0] act, input logic [31:0] expv);
        compared++;
        if (act !== expv) begin
            mismatched++;
            $display("FAIL %s: actual %0h expected %0h", t, act, expv);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic bit_cycle(input logic b, input logic e);
        tick(4);
        sda_m  = b;
        exp_oe = e;
        tick(LO - 4);
        scl_m = 1'b1;
        tick(HI);
        scl_m = 1'b0;
    endtask

    task automatic do_start();
        exp_oe = 1'b0;
        if (!scl_m) begin
            tick(4);
            sda_m = 1'b1;
            tick(4);
            scl_m = 1'b1;
        end
        tick(HI / 2);
        sda_m = 1'b0;
        tick(HI / 2);
        scl_m = 1'b0;
    endtask

    task automatic do_stop();
        tick(4);
        sda_m  = 1'b0;
        exp_oe = 1'b0;
        tick(4);
        scl_m = 1'b1;
        tick(HI / 2);
        sda_m = 1'b1;
        tick(HI);
    endtask

    task automatic send_byte(input logic [7:0] v, input logic ack_exp, input string t);
        tag = t;
        for (int i = 7; i >= 0; i--) bit_cycle(v[i], 1'b0);
        bit_cycle(1'b1, ack_exp);
    endtask

    task automatic recv_byte(input logic [7:0] v, input logic m_ack, input string t);
        tag = t;
        for (int i = 7; i >= 0; i--) bit_cycle(1'b1, ~v[i]);
        bit_cycle(~m_ack, 1'b0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin
            rf_val[i]  = 16'h0000;
            rf_wide[i] = 1'b0;
        end
        rf_val[5]      = 16'hA5C3;
        rf_wide[5]     = 1'b1;
        rf_val[8'h12]  = 16'h773C;
        rf_wide[8'h12] = 1'b0;

        tick(5);
        chk("R1", sda_oe, 0);
        chk("R1", reg_addr, 0);
        chk("R1", reg_we, 0);
        rst_n = 1'b1;
        tick(5);

        // R3: pointer write
        do_start();
        send_byte({ADDR, 1'b0}, 1'b1, "R2");
        send_byte(8'h05, 1'b1, "R3");
        do_stop();
        chk("R3", reg_addr, 8'h05);

        // R6: three wide pairs, last byte NACKed, then R8 release
        do_start();
        send_byte({ADDR, 1'b1}, 1'b1, "R2");
        recv_byte(8'hA5, 1'b1, "R6");
        recv_byte(8'hC3, 1'b1, "R6");
        recv_byte(8'hA5, 1'b1, "R6");
        recv_byte(8'hC3, 1'b1, "R6");
        recv_byte(8'hA5, 1'b1, "R6");
        recv_byte(8'hC3, 1'b0, "R6");
        send_byte(8'hFF, 1'b0, "R8");
        do_stop();
        chk("R5", reg_addr, 8'h05);

        // R9: pointer kept across STOP
        do_start();
        send_byte({ADDR, 1'b1}, 1'b1, "R9");
        recv_byte(8'hA5, 1'b1, "R9");
        recv_byte(8'hC3, 1'b0, "R9");
        do_stop();
        chk("R9", reg_addr, 8'h05);

        // R10: repeated START after pointer write; R5 narrow repeats
        do_start();
        send_byte({ADDR, 1'b0}, 1'b1, "R10");
        send_byte(8'h12, 1'b1, "R10");
        do_start();
        send_byte({ADDR, 1'b1}, 1'b1, "R10");
        recv_byte(8'h3C, 1'b1, "R5");
        recv_byte(8'h3C, 1'b1, "R5");
        recv_byte(8'h3C, 1'b0, "R5");
        do_stop();
        chk("R10", reg_addr, 8'h12);

        // R7: register changes between high and low byte
        do_start();
        send_byte({ADDR, 1'b0}, 1'b1, "R7");
        send_byte(8'h05, 1'b1, "R7");
        do_stop();
        do_start();
        send_byte({ADDR, 1'b1}, 1'b1, "R7");
        recv_byte(8'hA5, 1'b1, "R7");
        rf_val[5] = 16'h1234;
        recv_byte(8'hC3, 1'b1, "R7");
        recv_byte(8'h12, 1'b1, "R7");
        recv_byte(8'h34, 1'b0, "R7");
        do_stop();

        // R2: other address, write then read, never driven
        do_start();
        send_byte({7'h2D, 1'b0}, 1'b0, "R2");
        send_byte(8'h40, 1'b0, "R2");
        do_stop();
        do_start();
        send_byte({7'h2D, 1'b1}, 1'b0, "R2");
        send_byte(8'hFF, 1'b0, "R2");
        do_stop();
        chk("R2", reg_addr, 8'h05);
        chk("R2", wq.size(), 0);

        // R4: data bytes after the pointer
        do_start();
        send_byte({ADDR, 1'b0}, 1'b1, "R4");
        send_byte(8'h09, 1'b1, "R4");
        send_byte(8'h5A, 1'b1, "R4");
        send_byte(8'h6B, 1'b1, "R4");
        do_stop();
        chk("R4", wq.size(), 2);
        if (wq.size() == 2) begin
            chk("R4", wq[0], 8'h5A);
            chk("R4", wq[1], 8'h6B);
            chk("R4", wa[0], 8'h09);
            chk("R4", wa[1], 8'h09);
        end
        chk("R4", reg_addr, 8'h09);

        tick(10);
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            mismatched++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule